// File: doc/BRIEF.md
# Bias DAC Serial Command Sender

This block programs one bias value into an external two-wire DAC over a link that only writes. Both link wires live in a register byte that also carries unrelated power-enable bits. The link is driven purely by rewriting that whole byte. Each wire transition is therefore one full register write, presented on a parallel output with a one-cycle write strobe. A downstream register-write transport, which is not part of this block, delivers it.

A caller asserts `start_i` with an 8-bit value and a base pattern for the other register bits. The block then plays a fixed frame. The frame is a start condition, the byte 0x9C, the byte 0x00 and the value byte, with a dummy acknowledge clock after each byte, and then a stop condition. That makes 87 writes. Consecutive writes are spaced by a parameterised dwell, given in clock cycles. No acknowledge is ever sampled. When the final write's dwell has elapsed, the block drops busy and pulses done.

Top module: `bias_dac_sender`

## Requirements
- R1: After reset `busy_o`=0, `reg_wr_o`=0, `done_o`=0, and `reg_data_o`=0x03 (both link wires high, all other bits 0).
- R2: A `start_i` seen high at a clock edge while idle is accepted. In the cycle after that edge `busy_o`=1 and the first write strobe is present.
- R3: The clock wire is bit 0 and the data wire is bit 1 of `reg_data_o`. The first three writes form the start condition: (data,clock) = (1,1), then (0,1), then (0,0).
- R4: Each data bit takes three writes: data with clock 0, the same data with clock 1, then the same data with clock 0. Bits go most significant first.
- R5: After every byte, one extra three-write bit period is sent with data 0 (the acknowledge stand-in).
- R6: The bytes are sent in this order: 0x9C, 0x00, then the value latched at acceptance.
- R7: The last three writes form the stop condition: (data,clock) = (0,0), then (0,1), then (1,1). While idle the wires stay high.
- R8: Bits 7..2 of every write equal `base_i` as latched at acceptance. Changes of `base_i` or `value_i` during a transfer have no effect.
- R9: A transfer is exactly 87 single-cycle strobes, and consecutive strobes are exactly DWELL cycles apart.
- R10: `done_o` pulses for one cycle, DWELL cycles after the last strobe. In that same cycle `busy_o` falls.
- R11: A `start_i` raised while busy is ignored, and the running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one value |
| value_i | input | 8 | Bias value, sampled on acceptance |
| base_i | input | 8 | Pattern for the non-link register bits, sampled on acceptance |
| busy_o | output | 1 | Transfer in progress |
| reg_wr_o | output | 1 | One-cycle strobe for a register write |
| reg_data_o | output | 8 | Register byte to write |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The first strobe is due one edge after acceptance. Each later write follows exactly DWELL cycles after the one before. Done and the fall of busy come DWELL cycles after the 87th write. The bench stamps every strobe and the done pulse with a cycle count, sampling on the falling edge. It compares the differences of these stamps with those figures, not with fixed waits. The bench rebuilds the expected 87 register bytes by walking the frame structure of R3 to R7 on its own. It also scrambles the inputs mid-frame to cover R8 and R11.

// File: rtl/dac_send_pkg.sv
package dac_send_pkg;

  localparam int unsigned BITS_PER_BYTE = 8;
  localparam int unsigned SLOTS_PER_BYTE = BITS_PER_BYTE + 1;   // data bits plus ack
  localparam int unsigned WR_PER_SLOT = 3;
  localparam int unsigned N_BYTES = 3;
  localparam int unsigned COND_WRITES = 3;
  localparam int unsigned N_WRITES = 2 * COND_WRITES + N_BYTES * SLOTS_PER_BYTE * WR_PER_SLOT;
  localparam int unsigned IDX_W = $clog2(N_WRITES);

  typedef logic [IDX_W-1:0] step_idx_t;

  // Line levels for one step, returned as {data, clock}.
  function automatic logic [1:0] line_levels(input step_idx_t idx,
                                             input logic [7:0] b0,
                                             input logic [7:0] b1,
                                             input logic [7:0] b2);
    int unsigned k, body, slot, ph, byt, pos;
    logic [7:0] cur;
    logic d;
    k = int'(idx);
    if (k < COND_WRITES) begin
      case (k)
        0: return 2'b11;
        1: return 2'b01;
        default: return 2'b00;
      endcase
    end else if (k >= N_WRITES - COND_WRITES) begin
      case (k - (N_WRITES - COND_WRITES))
        0: return 2'b00;
        1: return 2'b01;
        default: return 2'b11;
      endcase
    end
    body = k - COND_WRITES;
    slot = body / WR_PER_SLOT;
    ph = body % WR_PER_SLOT;
    byt = slot / SLOTS_PER_BYTE;
    pos = slot % SLOTS_PER_BYTE;
    cur = (byt == 0) ? b0 : (byt == 1) ? b1 : b2;
    d = (pos == BITS_PER_BYTE) ? 1'b0 : cur[BITS_PER_BYTE-1-pos];
    return {d, (ph == 1)};
  endfunction

endpackage

// File: rtl/dac_dwell_timer.sv
module dac_dwell_timer #(
  parameter int unsigned DWELL = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DWELL < 2) ? 1 : $clog2(DWELL);
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [CW-1:0] cnt;

  assign tick = run && !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R9

endmodule

// File: rtl/dac_step_seq.sv
module dac_step_seq
  import dac_send_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      tick,
  output logic      accept,
  output logic      busy,
  output logic      stb,
  output logic      done,
  output step_idx_t idx
);
  localparam step_idx_t LAST_IDX = step_idx_t'(N_WRITES - 1);

  logic at_last;
  logic advance;
  logic finish;

  assign accept  = start && !busy;
  assign at_last = (idx == LAST_IDX);
  assign advance = busy && tick && !at_last;
  assign finish  = busy && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      stb  <= 1'b0;
      done <= 1'b0;
      idx  <= LAST_IDX;
    end else begin
      stb  <= accept || advance;
      done <= finish;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (advance) begin
        idx <= idx + 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  AST_STB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> busy); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && $past(busy)) |-> (idx == $past(idx) + 1'b1)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && stb) |-> (idx != '0)); // R11

endmodule

// File: rtl/dac_line_map.sv
module dac_line_map
  import dac_send_pkg::*;
#(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned CLK_BIT = 0,
  parameter int unsigned DAT_BIT = 1,
  parameter logic [7:0]  BYTE0   = 8'h9C,
  parameter logic [7:0]  BYTE1   = 8'h00
) (
  input  step_idx_t        idx,
  input  logic [7:0]       value,
  input  logic [REG_W-1:0] base,
  output logic [REG_W-1:0] data
);
  logic [1:0] lv;

  always_comb begin
    lv = line_levels(idx, BYTE0, BYTE1, value);
    data = base;
    data[CLK_BIT] = lv[0];
    data[DAT_BIT] = lv[1];
  end

endmodule

// File: rtl/bias_dac_sender.sv
module bias_dac_sender
  import dac_send_pkg::*;
#(
  parameter int unsigned DWELL   = 1000,
  parameter int unsigned REG_W   = 8,
  parameter int unsigned CLK_BIT = 0,
  parameter int unsigned DAT_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       value_i,
  input  logic [REG_W-1:0] base_i,
  output logic             busy_o,
  output logic             reg_wr_o,
  output logic [REG_W-1:0] reg_data_o,
  output logic             done_o
);
  logic             accept;
  logic             tick;
  step_idx_t        idx;
  logic [7:0]       value_q;
  logic [REG_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      base_q  <= '0;
    end else if (accept) begin
      value_q <= value_i;
      base_q  <= base_i;
    end
  end

  dac_dwell_timer #(.DWELL(DWELL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .run   (busy_o),
    .tick  (tick)
  );

  dac_step_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .tick   (tick),
    .accept (accept),
    .busy   (busy_o),
    .stb    (reg_wr_o),
    .done   (done_o),
    .idx    (idx)
  );

  dac_line_map #(
    .REG_W   (REG_W),
    .CLK_BIT (CLK_BIT),
    .DAT_BIT (DAT_BIT)
  ) u_map (
    .idx   (idx),
    .value (value_q),
    .base  (base_q),
    .data  (reg_data_o)
  );

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(base_q) && $stable(value_q))); // R8
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (reg_data_o[CLK_BIT] && reg_data_o[DAT_BIT])); // R7

endmodule

// File: tb/bias_dac_sender_tb.sv
module bias_dac_sender_tb;
  localparam int D = 3;
  localparam int NW = 87;
  localparam int NV = 6;
  // {value, base}
  localparam logic [15:0] VEC [NV] = '{16'h7D00, 16'h00FF, 16'hFFA4,
                                       16'h8003, 16'h015C, 16'h96F0};

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [7:0] value_i = 0, base_i = 0;
  logic busy_o, reg_wr_o, done_o;
  logic [7:0] reg_data_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] wdat [128];
  int wcyc [128];
  logic wbusy [128];
  int wr_n = 0, done_cyc = -1;
  logic done_busy;
  logic [7:0] exp_w [NW];
  int en;

  always #5 clk = ~clk;

  bias_dac_sender #(.DWELL(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .base_i(base_i), .busy_o(busy_o), .reg_wr_o(reg_wr_o),
    .reg_data_o(reg_data_o), .done_o(done_o));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (reg_wr_o && wr_n < 128) begin
      wdat[wr_n] = reg_data_o; wcyc[wr_n] = cyc; wbusy[wr_n] = busy_o;
      wr_n = wr_n + 1;
    end
    if (done_o) begin done_cyc = cyc; done_busy = busy_o; end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic push(input logic [7:0] b, input bit d, input bit c);
    exp_w[en] = {b[7:2], d, c};
    en++;
  endtask

  task automatic build(input logic [7:0] v, input logic [7:0] b);
    logic [7:0] bytes [3];
    bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = v;
    en = 0;
    push(b, 1, 1); push(b, 0, 1); push(b, 0, 0);          // R3 start
    foreach (bytes[j]) begin
      for (int i = 7; i >= 0; i--) begin                  // R4 MSB first
        push(b, bytes[j][i], 0); push(b, bytes[j][i], 1); push(b, bytes[j][i], 0);
      end
      push(b, 0, 0); push(b, 0, 1); push(b, 0, 0);        // R5 ack
    end
    push(b, 0, 0); push(b, 0, 1); push(b, 1, 1);          // R7 stop
  endtask

  task automatic run_xfer(input logic [7:0] v, input logic [7:0] b, input bit meddle);
    int acc;
    build(v, b);
    wr_n = 0; done_cyc = -1;
    @(negedge clk);
    value_i = v; base_i = b; start_i = 1;
    @(posedge clk); #1;
    acc = cyc;
    start_i = 0; value_i = ~v; base_i = ~b;                // R8 late input changes
    if (meddle) begin
      repeat (40) @(negedge clk);
      chk("R11 busy mid-frame", busy_o, 1);
      start_i = 1; value_i = 8'h55; base_i = 8'h3C;
      @(negedge clk); start_i = 0;
    end
    while (done_cyc < 0) @(negedge clk);
    @(negedge clk);
    chk("R9 write count", wr_n, NW);
    chk("R2 first strobe cycle", wcyc[0], acc);
    chk("R2 busy at first strobe", wbusy[0], 1);
    for (int k = 0; k < NW && k < wr_n; k++) begin
      chk($sformatf("R6/R8 write %0d data", k), wdat[k], exp_w[k]);
      if (k > 0) chk("R9 strobe spacing", wcyc[k] - wcyc[k-1], D);
    end
    chk("R10 done after last write", done_cyc - wcyc[NW-1], D);
    chk("R10 busy low at done", done_busy, 0);
    chk("R10 done single cycle", done_o, 0);
    chk("R7 idle lines high", reg_data_o[1:0], 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 strobe", reg_wr_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 data", reg_data_o, 8'h03);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobe", reg_wr_o, 0);
    for (int i = 0; i < NV; i++) begin
      run_xfer(VEC[i][15:8], VEC[i][7:0], 1'b0);
      repeat (2) @(negedge clk);
    end
    // R11: request during a transfer must not disturb it
    run_xfer(8'hC3, 8'h84, 1'b1);
    chk("R11 no restart after done", busy_o, 0);
    repeat (3) @(negedge clk);
    chk("R11 no stray strobe", wr_n, NW);
    finish_run();
  end

endmodule